// File: doc/BRIEF.md
# Upper Memory Limit Decoder

This block keeps the programmed ceiling of usable DRAM above the 4 GB line. It also classifies each host address against that ceiling. Software reaches an 8-byte configuration word through a byte-enabled register port. The word holds a limit field with 1 MB granularity and a self-locking protect bit. Every other bit position is reserved: it reads as zero, and whatever is written to it is discarded. An external trusted-mode input can freeze the word at any time, whatever the protect bit says.

On the host side an address arrives with a valid strobe. One clock later the block reports whether that address belongs to DRAM, which is true when it is at or above 4 GB and strictly below the ceiling. The valid strobe travels with the result. A ceiling at or below 4 GB, including the reset value of zero, produces no hits.

Top module: `upper_limit_decoder`

## Requirements
- R1: After reset the configuration word reads as all zeros and the hit output is low.
- R2: The limit field sits at bits 38:20 of the word, and the protect bit sits at bit 0. A write changes only the byte lanes whose enable bit is set (enable bit n covers data bits 8n+7..8n).
- R3: Bits 63:39 and 19:1 always read as zero, whatever is written to them.
- R4: Once the protect bit (bit 0) holds 1, every write is ignored, including attempts to clear the protect bit. This lasts until reset.
- R5: A single write that sets the protect bit and also changes the limit field stores both values. The protection applies from the following cycle onward.
- R6: While the trusted-mode lock input is high, writes leave the whole word unchanged, even when the protect bit is 0.
- R7: A valid address is a hit when it is at least 2^32 and strictly less than the limit field shifted left by 20. The low 20 bits of the ceiling count as zero.
- R8: When the limit field is at or below 4 GB (field value 0x1000 or less), no address is a hit.
- R9: The hit and its valid strobe appear one clock after the address is sampled. The hit is low whenever the strobe is low.
- R10: The word is reached only at byte offset A8h (the 8-byte window A8h..AFh). Writes to other offsets change nothing, and reads of other offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wr_en | input | 1 | Write strobe |
| cfg_be | input | 8 | Byte-lane enables |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data for the addressed window |
| trusted_lock | input | 1 | External trusted-mode write protection |
| host_vld | input | 1 | Host address valid |
| host_addr | input | 39 | Host address |
| dram_hit | output | 1 | Registered DRAM-above-4GB hit |
| dram_hit_vld | output | 1 | Registered copy of host_vld |

## Verification
The bench probes addresses that sit on either side of each boundary: just under 4 GB, exactly 4 GB, the last MB below the ceiling, and the ceiling itself. These cases separate an inclusive compare from an exclusive one. It repeats the probes with ceilings below, at and above 4 GB, which shows whether the lower bound really suppresses hits. Single-lane writes, writes to neighbouring offsets, writes made under trusted lock, and a write that sets the protect bit together with a new limit show which paths can modify the stored word. A long stretch of random traffic is also compared every clock against a behavioural model.

// File: rtl/ulim_pkg.sv
`timescale 1ns/1ps
package ulim_pkg;
   localparam int REG_BYTES = 8;
   localparam int REG_W     = REG_BYTES * 8;
   localparam int LOCK_BIT  = 0;

   typedef logic [REG_W-1:0]     cfg_word_t;
   typedef logic [REG_BYTES-1:0] cfg_be_t;

   // bits that software can change: the protect bit plus the limit field
   function automatic cfg_word_t writable_mask(input int addr_w, input int lim_lsb);
      cfg_word_t m;
      m = '0;
      for (int i = 0; i < REG_W; i++) begin
         if (i == LOCK_BIT || (i >= lim_lsb && i < addr_w)) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/ulim_win_decode.sv
`timescale 1ns/1ps
module ulim_win_decode
   import ulim_pkg::*;
#(
   parameter int               CFG_AW = 12,
   parameter logic [CFG_AW-1:0] OFFSET = 12'hA8
) (
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic              cfg_wr_en,
   input  cfg_word_t         word_i,
   output logic              sel_wr_o,
   output cfg_word_t         rdata_o
);
   localparam int BYTE_SEL_W = $clog2(REG_BYTES);

   if (OFFSET[BYTE_SEL_W-1:0] != '0) begin : g_bad_align
      $error("window offset must be aligned to the word size");
   end

   logic sel;
   assign sel      = (cfg_addr[CFG_AW-1:BYTE_SEL_W] == OFFSET[CFG_AW-1:BYTE_SEL_W]);
   assign sel_wr_o = sel & cfg_wr_en;
   assign rdata_o  = sel ? word_i : '0;
endmodule

// File: rtl/ulim_cfg_reg.sv
`timescale 1ns/1ps
module ulim_cfg_reg
   import ulim_pkg::*;
#(
   parameter int ADDR_W  = 39,
   parameter int LIM_LSB = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_go,
   input  cfg_be_t                 be,
   input  cfg_word_t               wdata,
   input  logic                    trusted_lock,
   output cfg_word_t               word_o,
   output logic [ADDR_W-1:LIM_LSB] limit_o
);
   localparam cfg_word_t WMASK = writable_mask(ADDR_W, LIM_LSB);

   logic wr_ok;
   logic lock_q;

   assign lock_q = word_o[LOCK_BIT];
   assign wr_ok  = wr_go & ~lock_q & ~trusted_lock;

   for (genvar b = 0; b < REG_BYTES; b++) begin : g_lane
      localparam logic [7:0] LMASK = WMASK[b*8 +: 8];
      if (LMASK == 8'h00) begin : g_reserved
         assign word_o[b*8 +: 8] = 8'h00;
      end else begin : g_store
         logic [7:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               lane_q <= 8'h00;
            else if (wr_ok && be[b])  lane_q <= wdata[b*8 +: 8] & LMASK;
         end
         assign word_o[b*8 +: 8] = lane_q;
      end
   end

   assign limit_o = word_o[ADDR_W-1:LIM_LSB];

   // R4: protect bit cannot be cleared by software
   a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
   // R4: nothing changes once protected
   a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(word_o));
   // R6: trusted mode freezes the word
   a_r6_trusted_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      trusted_lock |=> word_o == $past(word_o));
   // R2: a full-lane accepted write lands with reserved bits dropped
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && !lock_q && !trusted_lock && &be) |=> word_o == ($past(wdata) & WMASK));
endmodule

// File: rtl/ulim_range_cmp.sv
`timescale 1ns/1ps
module ulim_range_cmp #(
   parameter int ADDR_W   = 39,
   parameter int LIM_LSB  = 20,
   parameter int BASE_BIT = 32,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [ADDR_W-1:LIM_LSB] limit_i,
   output logic                    hit_o,
   output logic                    vld_o
);
   localparam int LW = ADDR_W - LIM_LSB;
   localparam logic [LW-1:0] BASE_FIELD = LW'(1) << (BASE_BIT - LIM_LSB);

   logic above_base, below_lim, hit_c;
   assign above_base = |addr_i[ADDR_W-1:BASE_BIT];
   assign below_lim  = addr_i[ADDR_W-1:LIM_LSB] < limit_i;
   assign hit_c      = vld_i & above_base & below_lim;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_o <= 1'b0;
            vld_o <= 1'b0;
         end else begin
            hit_o <= hit_c;
            vld_o <= vld_i;
         end
      end

      a_r9_hit_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
         hit_o |-> vld_o);
      a_r9_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i |=> vld_o);
      a_r9_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
         !vld_i |=> !vld_o);
      a_r7_below_base_miss: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_i && addr_i[ADDR_W-1:BASE_BIT] == '0) |=> !hit_o);
      a_r8_low_limit_miss: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_i && limit_i <= BASE_FIELD) |=> !hit_o);
   end else begin : g_comb
      assign hit_o = hit_c;
      assign vld_o = vld_i;
   end
endmodule

// File: rtl/upper_limit_decoder.sv
`timescale 1ns/1ps
module upper_limit_decoder
   import ulim_pkg::*;
#(
   parameter int              CFG_AW   = 12,
   parameter logic [CFG_AW-1:0] WIN_OFF = 12'hA8,
   parameter int              ADDR_W   = 39,
   parameter int              LIM_LSB  = 20,
   parameter int              BASE_BIT = 32,
   parameter bit              OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic              cfg_wr_en,
   input  logic [7:0]        cfg_be,
   input  logic [63:0]       cfg_wdata,
   output logic [63:0]       cfg_rdata,
   input  logic              trusted_lock,
   input  logic              host_vld,
   input  logic [ADDR_W-1:0] host_addr,
   output logic              dram_hit,
   output logic              dram_hit_vld
);
   if (ADDR_W > REG_W || ADDR_W <= BASE_BIT) begin : g_bad_aw
      $error("address width must exceed the base bit and fit the word");
   end
   if (LIM_LSB <= LOCK_BIT || LIM_LSB > BASE_BIT) begin : g_bad_lsb
      $error("limit field must sit above the protect bit and not above the base");
   end

   logic                    sel_wr;
   cfg_word_t               word;
   logic [ADDR_W-1:LIM_LSB] limit;

   ulim_win_decode #(.CFG_AW(CFG_AW), .OFFSET(WIN_OFF)) u_win (
      .cfg_addr (cfg_addr),
      .cfg_wr_en(cfg_wr_en),
      .word_i   (word),
      .sel_wr_o (sel_wr),
      .rdata_o  (cfg_rdata)
   );

   ulim_cfg_reg #(.ADDR_W(ADDR_W), .LIM_LSB(LIM_LSB)) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_go       (sel_wr),
      .be          (cfg_be),
      .wdata       (cfg_wdata),
      .trusted_lock(trusted_lock),
      .word_o      (word),
      .limit_o     (limit)
   );

   ulim_range_cmp #(.ADDR_W(ADDR_W), .LIM_LSB(LIM_LSB), .BASE_BIT(BASE_BIT),
                    .OUT_REG(OUT_REG)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (host_vld),
      .addr_i (host_addr),
      .limit_i(limit),
      .hit_o  (dram_hit),
      .vld_o  (dram_hit_vld)
   );

   // R10: an off-window write leaves the word untouched
   a_r10_offwin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && !sel_wr) |=> $stable(word));
endmodule

// File: tb/upper_limit_decoder_tb.sv
`timescale 1ns/1ps
module upper_limit_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_addr = 12'hA8;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_be = 8'h00;
   logic [63:0] cfg_wdata = 64'h0;
   logic [63:0] cfg_rdata;
   logic        trusted_lock = 1'b0;
   logic        host_vld = 1'b0;
   logic [38:0] host_addr = 39'h0;
   logic        dram_hit, dram_hit_vld;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   upper_limit_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .trusted_lock(trusted_lock), .host_vld(host_vld), .host_addr(host_addr),
      .dram_hit(dram_hit), .dram_hit_vld(dram_hit_vld)
   );

   // behavioural model
   localparam logic [63:0] WMASK = 64'h0000_007F_FFF0_0001;
   logic [63:0] m_word;
   logic        m_vld, m_hit;

   always @(posedge clk or negedge rst_n) begin : model
      logic [63:0] nx;
      logic [63:0] a64, lim64;
      if (!rst_n) begin
         m_word <= 64'h0;
         m_vld  <= 1'b0;
         m_hit  <= 1'b0;
      end else begin
         nx = m_word;
         if (cfg_wr_en && cfg_addr[11:3] == 9'h15 && !m_word[0] && !trusted_lock)
            for (int b = 0; b < 8; b++)
               if (cfg_be[b]) nx[b*8 +: 8] = cfg_wdata[b*8 +: 8] & WMASK[b*8 +: 8];
         a64   = {25'h0, host_addr};
         lim64 = {25'h0, m_word[38:20], 20'h0};
         m_word <= nx;
         m_vld  <= host_vld;
         m_hit  <= host_vld && (a64 >= 64'h1_0000_0000) && (a64 < lim64);
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10 rdata vs model", cfg_rdata, (cfg_addr[11:3] == 9'h15) ? m_word : 64'h0);
         chk("R9 valid vs model", {63'h0, dram_hit_vld}, {63'h0, m_vld});
         chk("R7 hit vs model", {63'h0, dram_hit}, {63'h0, m_hit});
      end
   end

   task automatic wr(input logic [11:0] a, input logic [7:0] be, input logic [63:0] d);
      @(negedge clk); #1;
      cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr_en = 1'b1;
      @(negedge clk); #1;
      cfg_wr_en = 1'b0; cfg_addr = 12'hA8;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [63:0] exp);
      @(negedge clk); #1;
      cfg_addr = a;
      @(negedge clk);
      chk(req, cfg_rdata, exp);
      #1 cfg_addr = 12'hA8;
   endtask

   task automatic probe(input string req, input logic [38:0] a, input logic exp);
      @(negedge clk); #1;
      host_vld = 1'b1; host_addr = a;
      @(negedge clk);
      chk(req, {63'h0, dram_hit}, {63'h0, exp});
      #1 host_vld = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 rdata in reset", cfg_rdata, 64'h0);
      chk("R1 hit in reset", {63'h0, dram_hit}, 64'h0);
      #1 rst_n = 1'b1;

      // R8: zero limit gives no hit
      probe("R8 reset limit 5GB", 39'h1_4000_0000, 1'b0);

      // R3: reserved bits drop
      wr(12'hA8, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFE);
      rd_chk("R3 reserved read zero", 12'hA8, 64'h0000_007F_FFF0_0000);

      // R7: boundaries with a 6GB ceiling
      wr(12'hA8, 8'hFF, 64'h0000_0001_8000_0000);
      probe("R7 just under 4GB", 39'h0_FFFF_FFFF, 1'b0);
      probe("R7 exactly 4GB", 39'h1_0000_0000, 1'b1);
      probe("R7 last byte below ceiling", 39'h1_7FFF_FFFF, 1'b1);
      probe("R7 at ceiling", 39'h1_8000_0000, 1'b0);

      // R2: single byte lane
      wr(12'hA8, 8'h10, 64'h0000_0002_0000_0000);
      rd_chk("R2 lane 4 only", 12'hA8, 64'h0000_0002_8000_0000);
      probe("R2 new ceiling used", 39'h2_7FF0_0000, 1'b1);

      // R8: ceilings below and at 4GB
      wr(12'hA8, 8'hFF, 64'h0000_0000_C000_0000);
      probe("R8 3GB ceiling at 4GB", 39'h1_0000_0000, 1'b0);
      probe("R8 3GB ceiling at 2GB", 39'h0_8000_0000, 1'b0);
      wr(12'hA8, 8'hFF, 64'h0000_0001_0000_0000);
      probe("R8 4GB ceiling at 4GB", 39'h1_0000_0000, 1'b0);

      // R10: other offsets
      wr(12'hA0, 8'hFF, 64'h0000_0003_0000_0000);
      wr(12'hB0, 8'hFF, 64'h0000_0003_0000_0000);
      rd_chk("R10 word unchanged", 12'hA8, 64'h0000_0001_0000_0000);
      rd_chk("R10 other offset reads zero", 12'hA0, 64'h0);
      rd_chk("R10 upper byte of window", 12'hAF, 64'h0000_0001_0000_0000);

      // R6: trusted mode
      wr(12'hA8, 8'hFF, 64'h0000_0001_4000_0000);
      @(negedge clk); #1 trusted_lock = 1'b1;
      wr(12'hA8, 8'hFF, 64'h0000_0002_0000_0000);
      rd_chk("R6 write blocked", 12'hA8, 64'h0000_0001_4000_0000);
      @(negedge clk); #1 trusted_lock = 1'b0;

      // R9: no strobe
      @(negedge clk); #1 host_addr = 39'h1_0000_0000; host_vld = 1'b0;
      @(negedge clk);
      chk("R9 no valid no hit", {62'h0, dram_hit_vld, dram_hit}, 64'h0);

      // random traffic, protect bit kept clear
      for (int i = 0; i < 400; i++) begin
         @(negedge clk); #1;
         cfg_wr_en    = ($urandom % 3) == 0;
         cfg_addr     = (($urandom % 4) == 0) ? 12'hB0 : 12'hA8;
         cfg_be       = 8'($urandom);
         cfg_wdata    = {32'($urandom), 32'($urandom)} & ~64'h1;
         cfg_wdata[38:36] = 3'($urandom % 2);
         trusted_lock = ($urandom % 8) == 0;
         host_vld     = 1'($urandom);
         host_addr    = {3'($urandom % 3), 36'({$urandom, $urandom})};
      end
      @(negedge clk); #1;
      cfg_wr_en = 1'b0; trusted_lock = 1'b0; host_vld = 1'b0; cfg_addr = 12'hA8;

      // R5: protect and limit in one write
      wr(12'hA8, 8'hFF, 64'h0000_0002_0000_0001);
      rd_chk("R5 both stored", 12'hA8, 64'h0000_0002_0000_0001);
      // R4: later writes ignored
      wr(12'hA8, 8'hFF, 64'h0);
      rd_chk("R4 clear attempt ignored", 12'hA8, 64'h0000_0002_0000_0001);
      wr(12'hA8, 8'h1C, 64'h0000_0003_0000_0000);
      rd_chk("R4 limit write ignored", 12'hA8, 64'h0000_0002_0000_0001);
      probe("R4 locked ceiling in use", 39'h1_FFF0_0000, 1'b1);

      // R1/R4: reset releases protection
      @(negedge clk); #1 rst_n = 1'b0;
      @(negedge clk);
      chk("R1 rdata after reset", cfg_rdata, 64'h0);
      #1 rst_n = 1'b1;
      wr(12'hA8, 8'hFF, 64'h0000_0003_0000_0000);
      rd_chk("R4 writable after reset", 12'hA8, 64'h0000_0003_0000_0000);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule